// File: doc/BRIEF.md
# Load/Store Access Guard

The access guard looks at every data memory access before it reaches the bus and decides whether it must be trapped. Two checks run side by side on each access. The first is an alignment test driven by the access width. The second is a bounds test that applies only to accesses marked as stack traffic, using a low and a high limit held elsewhere in the core.

When either check fails, the guard records the offending address and a cause word on the next clock edge. The cause word says which check failed and, for a misaligned access, also records the direction, the width and the destination register. A one-cycle raise request goes to the exception logic with that update. A misaligned access updates the recorded state even when exceptions are disabled, but it only asks for an exception when the enable input is high. A stack violation always asks for one.

Top module: `lsu_access_guard`

## Requirements
- R1: While reset is asserted, `faultAddr`, `causeWord` and `raiseExc` are all zero.
- R2: The width code `accSize` is 0 for byte, 1 for halfword, 2 for word, and 3 is treated as word. The alignment mask is 0, 1 and 3 respectively. An access is misaligned when the low address bits ANDed with the mask are non-zero, so byte accesses never fail this check.
- R3: After a failing access, `faultAddr` holds that access's address from the next clock edge on.
- R4: A misaligned access sets `causeWord` to cause code 5'h01 in bits 4:0, the destination register in bits 9:5, the store flag in bit 10 and a word-width flag in bit 11 (set for width codes 2 and 3), with all other bits zero.
- R5: A misaligned access pulses `raiseExc` only when `excEnable` is high. `faultAddr` and `causeWord` are updated whatever the value of `excEnable`.
- R6: A stack access with an address below `stackLow` or above `stackHigh` (unsigned compare, both limits inclusive-legal) is a violation. It sets `causeWord` to 32'h0000_0007 and `faultAddr` to the address, and it pulses `raiseExc` whatever the value of `excEnable`.
- R7: When an access is both misaligned and out of stack bounds, the alignment result wins: the R4 cause is stored and the raise follows R5.
- R8: A passing access, or a non-stack access outside the limits, leaves `faultAddr` and `causeWord` unchanged and keeps `raiseExc` low.
- R9: `raiseExc` is high for exactly the cycle after a failing access. Cycles with `accValid` low leave all outputs unchanged, except that `raiseExc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | ADDR_W | Effective address |
| accSize | input | 2 | Width code (R2) |
| accIsStore | input | 1 | 1 for store, 0 for load |
| accDestReg | input | 5 | Destination register number |
| accIsStack | input | 1 | Access goes through the stack pointer |
| stackLow | input | ADDR_W | Lowest legal stack address |
| stackHigh | input | ADDR_W | Highest legal stack address |
| excEnable | input | 1 | Exceptions enabled |
| faultAddr | output | ADDR_W | Recorded faulting address |
| causeWord | output | 32 | Recorded cause word |
| raiseExc | output | 1 | One-cycle exception request |

## Verification
The bench sweeps every width code against all four low-address offsets, both directions and both enable levels. This sorts accesses that really are misaligned from aligned ones, and shows that the enable input affects only the raise. Each of those patterns is repeated as non-stack, in-bounds stack, below-limit stack and above-limit stack traffic. That separates the bounds check from the alignment check and exposes the priority when both fail. Accesses exactly on each limit and one step beyond it pin down whether the compare is inclusive, and idle cycles between faults show that the state holds and the raise is a single pulse.

// File: rtl/lsu_guard_pkg.sv
package lsu_guard_pkg;

  localparam int CAUSE_W      = 32;
  localparam int CODE_W       = 5;
  localparam int DEST_LSB     = 5;
  localparam int DEST_W       = 5;
  localparam int STORE_BIT    = DEST_LSB + DEST_W;
  localparam int WORD_BIT     = STORE_BIT + 1;

  localparam logic [CODE_W-1:0] CODE_MISALIGN = 5'h01;
  localparam logic [CODE_W-1:0] CODE_STACK    = 5'h07;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  typedef struct packed {
    logic capture;
    logic selStack;
    logic raise;
  } guardStrb_t;

  function automatic logic [1:0] sizeMask(input logic [1:0] sz);
    case (accSize_e'(sz))
      SZ_BYTE: return 2'b00;
      SZ_HALF: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/lsu_guard_ctrl.sv
module lsu_guard_ctrl
  import lsu_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsStack,
  input  logic [ADDR_W-1:0] stackLow,
  input  logic [ADDR_W-1:0] stackHigh,
  input  logic              excEnable,
  output guardStrb_t        strb,
  output logic              isWord
);

  logic [1:0] mask;
  logic       misAligned;
  logic       belowLow;
  logic       aboveHigh;
  logic       stackViol;

  always_comb begin
    mask       = sizeMask(accSize);
    misAligned = accValid && ((accAddr[1:0] & mask) != 2'b00);
    belowLow   = accAddr < stackLow;
    aboveHigh  = accAddr > stackHigh;
    stackViol  = accValid && accIsStack && (belowLow || aboveHigh);
    isWord     = (mask == 2'b11);

    strb.capture  = misAligned || stackViol;
    strb.selStack = !misAligned && stackViol;
    strb.raise    = misAligned ? excEnable : stackViol;
  end

  // Byte traffic outside the stack can never be trapped (R2).
  p_byte_no_trap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSize == 2'd0 && !accIsStack) |-> !strb.capture);

  // A raise request is always accompanied by a capture (R5, R6).
  p_raise_with_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.raise |-> strb.capture);

endmodule

// File: rtl/lsu_guard_dp.sv
module lsu_guard_dp
  import lsu_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  guardStrb_t         strb,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               isStore,
  input  logic               isWord,
  input  logic [DEST_W-1:0]  destReg,
  output logic [ADDR_W-1:0]  faultAddr,
  output logic [CAUSE_W-1:0] causeWord,
  output logic               raiseExc
);

  logic [CAUSE_W-1:0] causeNext;

  always_comb begin
    causeNext = '0;
    if (strb.selStack) begin
      causeNext[CODE_W-1:0] = CODE_STACK;
    end else begin
      causeNext[CODE_W-1:0]               = CODE_MISALIGN;
      causeNext[DEST_LSB +: DEST_W]       = destReg;
      causeNext[STORE_BIT]                = isStore;
      causeNext[WORD_BIT]                 = isWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultAddr <= '0;
      causeWord <= '0;
      raiseExc  <= 1'b0;
    end else begin
      raiseExc <= strb.raise;
      if (strb.capture) begin
        faultAddr <= addrIn;
        causeWord <= causeNext;
      end
    end
  end

  // Captured address follows the failing access by one cycle (R3).
  p_capture_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (faultAddr == $past(addrIn)));

  // Without a capture the recorded state holds (R8).
  p_hold_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(faultAddr) && $stable(causeWord)));

endmodule

// File: rtl/lsu_access_guard.sv
module lsu_access_guard
  import lsu_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accIsStore,
  input  logic [4:0]        accDestReg,
  input  logic              accIsStack,
  input  logic [ADDR_W-1:0] stackLow,
  input  logic [ADDR_W-1:0] stackHigh,
  input  logic              excEnable,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [31:0]       causeWord,
  output logic              raiseExc
);

  guardStrb_t strb;
  logic       isWord;

  lsu_guard_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accSize   (accSize),
    .accAddr   (accAddr),
    .accIsStack(accIsStack),
    .stackLow  (stackLow),
    .stackHigh (stackHigh),
    .excEnable (excEnable),
    .strb      (strb),
    .isWord    (isWord)
  );

  lsu_guard_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrIn    (accAddr),
    .isStore   (accIsStore),
    .isWord    (isWord),
    .destReg   (accDestReg),
    .faultAddr (faultAddr),
    .causeWord (causeWord),
    .raiseExc  (raiseExc)
  );

  // Idle cycles keep everything still and never raise (R9).
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!raiseExc && $stable(faultAddr) && $stable(causeWord)));

  // Aligned stack access under the low limit always raises (R6).
  p_stack_low_raise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStack && ((accAddr[1:0] & sizeMask(accSize)) == 2'b00)
     && (accAddr < stackLow)) |=> (raiseExc && causeWord == 32'h7));

  // Misaligned access with exceptions off records but never raises (R5).
  p_masked_no_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !excEnable && ((accAddr[1:0] & sizeMask(accSize)) != 2'b00))
     |=> (!raiseExc && causeWord[4:0] == 5'h01));

endmodule

// File: tb/lsu_access_guard_tb_top.sv
module lsu_access_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LIM_LO = 32'h0000_1000;
  localparam logic [31:0] LIM_HI = 32'h0000_1FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic        accIsStore = 1'b0;
  logic [4:0]  accDestReg = '0;
  logic        accIsStack = 1'b0;
  logic [31:0] stackLow = LIM_LO;
  logic [31:0] stackHigh = LIM_HI;
  logic        excEnable = 1'b0;
  logic [31:0] faultAddr;
  logic [31:0] causeWord;
  logic        raiseExc;

  int testCount = 0;
  int failCount = 0;

  logic [31:0] expAddr = '0;
  logic [31:0] expCause = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_access_guard #(.ADDR_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accSize(accSize), .accIsStore(accIsStore), .accDestReg(accDestReg),
    .accIsStack(accIsStack), .stackLow(stackLow), .stackHigh(stackHigh),
    .excEnable(excEnable), .faultAddr(faultAddr), .causeWord(causeWord),
    .raiseExc(raiseExc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] addr, input logic [1:0] sz,
                        input logic st, input logic [4:0] dest,
                        input logic stk, input logic en);
    logic [1:0] mask;
    logic mis, sv, eRaise;
    string tagState, tagRaise;
    accValid = 1'b1; accAddr = addr; accSize = sz; accIsStore = st;
    accDestReg = dest; accIsStack = stk; excEnable = en;
    mask = (sz == 2'd0) ? 2'b00 : (sz == 2'd1) ? 2'b01 : 2'b11;
    mis = (addr[1:0] & mask) != 2'b00;
    sv  = stk && ((addr < stackLow) || (addr > stackHigh));
    eRaise = 1'b0;
    if (mis) begin
      expAddr = addr;
      expCause = {20'b0, (mask == 2'b11), st, dest, 5'h01};
      eRaise = en;
    end else if (sv) begin
      expAddr = addr;
      expCause = 32'h0000_0007;
      eRaise = 1'b1;
    end
    tagState = (mis && sv) ? "R7" : mis ? "R4" : sv ? "R6" : "R8";
    tagRaise = (mis && sv) ? "R7" : mis ? "R5" : sv ? "R6" : "R2 R8";
    @(negedge clk);
    chk({tagState, " cause"}, causeWord, expCause);
    chk(mis || sv ? "R3 addr" : "R8 addr", faultAddr, expAddr);
    chk({tagRaise, " raise"}, {31'b0, raiseExc}, {31'b0, eRaise});
  endtask

  task automatic idle();
    accValid = 1'b0;
    accAddr = 32'hFFFF_FFFF; accIsStack = 1'b1; accSize = 2'd2;
    @(negedge clk);
    chk("R9 idle raise", {31'b0, raiseExc}, 32'h0);
    chk("R9 idle addr", faultAddr, expAddr);
    chk("R9 idle cause", causeWord, expCause);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset addr", faultAddr, 32'h0);
    chk("R1 reset cause", causeWord, 32'h0);
    chk("R1 reset raise", {31'b0, raiseExc}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int mode = 0; mode < 4; mode++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int lo = 0; lo < 4; lo++) begin
          for (int st = 0; st < 2; st++) begin
            for (int en = 0; en < 2; en++) begin
              logic [31:0] base;
              base = (mode == 1) ? 32'h0000_1800 :
                     (mode == 3) ? 32'h0000_2000 : 32'h0000_0F00;
              access(base + 32'(lo), 2'(sz), st[0],
                     5'((sz * 7 + lo * 3 + st + en * 11) % 32),
                     mode != 0, en[0]);
            end
          end
        end
        idle();
      end
    end

    // Limit edges: inclusive bounds legal, one step beyond traps (R6)
    access(LIM_LO, 2'd0, 1'b0, 5'd3, 1'b1, 1'b0);
    access(LIM_HI, 2'd0, 1'b1, 5'd4, 1'b1, 1'b0);
    access(LIM_LO - 32'd1, 2'd0, 1'b0, 5'd5, 1'b1, 1'b0);
    idle();
    access(LIM_HI + 32'd1, 2'd0, 1'b1, 5'd6, 1'b1, 1'b0);
    // Back-to-back faults then quiet: raise is one pulse per access (R9)
    access(32'h0000_1802, 2'd2, 1'b1, 5'd31, 1'b0, 1'b1);
    access(32'h0000_1803, 2'd1, 1'b0, 5'd17, 1'b0, 1'b1);
    idle();
    idle();

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule